// File: doc/BRIEF.md
# SPI Frame-Length Checker with Interrupt-Enable Register

This block is the slave-side serial front end of a control chip that speaks fixed 16-bit SPI frames. The serial pins are brought into the system clock domain through two-stage synchronizers. The frame is shifted in MSB first on rising SCK. At the same time, the current interrupt-enable word is shifted out on MISO, changing on falling SCK. Each frame is judged only when chip select is released.

A frame carries a 2-bit register address in its two top bits and a read-select bit just below them. A frame with exactly sixteen clocks, address `01` and read-select set loads new enable bits. The old contents have already gone out on MISO during that frame. With read-select clear, the frame is a pure read. A frame with any other clock count is rejected. Whether the rejection is silent, raises an interrupt pulse or requests a reset depends on the SPI-failure enable bit and on whether the chip is in a strict (start-up or restart) mode.

Top module: `spi_frame_chk`

## Requirements
- R1: The enable register changes only when chip select rises after exactly 16 rising SCK edges. The new value is visible three system clocks after the CSN rise at the pin.
- R2: Only frames whose bits [15:14] equal `01` can modify the enable register. Other addresses leave it unchanged.
- R3: A valid frame with read-select (bit 13) equal to 0 leaves the enable register unchanged.
- R4: A valid frame to address `01` with bit 13 equal to 1 loads bits [11:0] into the enable register. Bit 12 is ignored. The same frame returns the previous contents on MISO.
- R5: Enable bits 11 and 10 are reserved. They always read 0, whatever value is written.
- R6: A frame with any clock count other than 16 never modifies the register. When enable bit 3 (SPI failure) is 0, such a frame also produces no irq_pulse and no rst_req.
- R7: With enable bit 3 set and mode_strict low, a wrong-length frame gives a one-cycle irq_pulse, in the same cycle that a valid frame would update the register.
- R8: With enable bit 3 set and mode_strict high, a wrong-length frame gives a one-cycle rst_req and no irq_pulse.
- R9: During a frame, MISO carries the word {4'b0000, enable[11:0]} captured at CSN fall. It is sent MSB first, with each later bit changing after a falling SCK edge.
- R10: The clock counter saturates at 17, so any overrun (for example 20 clocks) or a frame with zero clocks is treated as wrong-length.
- R11: After reset the enable register is 0 and irq_pulse, rst_req and miso are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in, sampled on rising SCK |
| spi_miso | output | 1 | Serial data out, updated on falling SCK |
| mode_strict | input | 1 | High in start-up/restart modes: escalate bad frames to reset |
| ien | output | 12 | Interrupt-enable register contents |
| irq_pulse | output | 1 | One-cycle interrupt on a wrong-length frame |
| rst_req | output | 1 | One-cycle reset request on a wrong-length frame |

## Verification
Some properties are checked by assertions on every cycle. The reserved bits stay at zero. The counter never passes its saturation value. The register moves only right after a chip-select release. The interrupt and reset pulses last one cycle and never occur together. Other behaviour can only be shown by the bench scenarios: that 15, 17, 20 and zero clocks are rejected, the choice between silence, interrupt and reset, the read-only versus read-while-write split, the address decode, and the MISO word returning the previous contents.

// File: rtl/spi_frame_chk.sv
module spi_frame_chk #(
  parameter int          FW        = 16,
  parameter int          DW        = 12,
  parameter int          RS_BIT    = 13,
  parameter int          FAIL_BIT  = 3,
  parameter logic [1:0]  IEF_ADDR  = 2'b01,
  parameter logic [11:0] RSV_MASK  = 12'hC00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_csn,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          mode_strict,
  output logic [DW-1:0] ien,
  output logic          irq_pulse,
  output logic          rst_req
);
  localparam int CW  = $clog2(FW + 2);
  localparam int SAT = FW + 1;

  logic [2:0]    sck_q, csn_q;
  logic [1:0]    mosi_q;
  logic [FW-1:0] rx_sh, tx_sh;
  logic [CW-1:0] cnt;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_fall  = ~csn_q[1] & csn_q[2];
  wire cs_rise  = csn_q[1] & ~csn_q[2];
  wire active   = ~csn_q[1];
  wire frame_ok = (cnt == CW'(FW));
  wire hit      = (rx_sh[FW-1:FW-2] == IEF_ADDR) & rx_sh[RS_BIT];
  wire bad_end  = cs_rise & ~frame_ok & ien[FAIL_BIT];

  assign spi_miso = tx_sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 3'b000;
      csn_q  <= 3'b111;
      mosi_q <= 2'b00;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      csn_q  <= {csn_q[1:0], spi_csn};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0;
      tx_sh <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      cnt   <= '0;
      tx_sh <= {{(FW-DW){1'b0}}, ien};
    end else if (active) begin
      if (sck_rise) begin
        rx_sh <= {rx_sh[FW-2:0], mosi_q[1]};
        if (cnt != CW'(SAT)) cnt <= cnt + 1'b1;
      end
      if (sck_fall) tx_sh <= {tx_sh[FW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien       <= '0;
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      if (cs_rise && frame_ok && hit) ien <= rx_sh[DW-1:0] & ~RSV_MASK[DW-1:0];
      irq_pulse <= bad_end & ~mode_strict;
      rst_req   <= bad_end & mode_strict;
    end
  end

  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(SAT));

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien & RSV_MASK[DW-1:0]) == '0);

  // R1
  ien_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ien) |-> $past(cs_rise));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R8
  excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && rst_req));

  // R8
  rst_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(mode_strict));
endmodule

// File: tb/spi_frame_chk_tb_top.sv
module spi_frame_chk_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 150000;

  logic clk = 0, rst_n = 0;
  logic sck = 0, csn = 1, mosi = 0, strict = 0;
  logic miso, irq, rst_req;
  logic [11:0] ien;

  int checks = 0, errors = 0, cyc = 0;
  logic [11:0] m_ien = 0;
  logic m_irq = 0, m_rst = 0;
  logic [15:0] rd;

  spi_frame_chk dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .mode_strict(strict), .ien(ien), .irq_pulse(irq), .rst_req(rst_req)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    check(ien == m_ien, "R1 ien per-cycle", ien, m_ien);
    check(irq == m_irq, "R7 irq per-cycle", irq, m_irq);
    check(rst_req == m_rst, "R8 rst_req per-cycle", rst_req, m_rst);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic frame(input logic [15:0] w, input int n, input bit st);
    logic [11:0] nxt;
    logic pi, pr;
    strict = st;
    rd = '0;
    csn = 0;
    ticks(4);
    for (int i = 0; i < n; i++) begin
      sck = 0;
      mosi = (i < 16) ? w[15-i] : 1'b0;
      ticks(4);
      if (i < 16) rd[15-i] = miso;
      sck = 1;
      ticks(4);
    end
    sck = 0;
    ticks(4);
    csn = 1;
    nxt = m_ien; pi = 0; pr = 0;
    if (n == 16) begin
      if (w[15:14] == 2'b01 && w[13]) nxt = w[11:0] & 12'h3FF;
    end else if (m_ien[3]) begin
      if (st) pr = 1; else pi = 1;
    end
    ticks(2);
    m_ien = nxt; m_irq = pi; m_rst = pr;
    tick();
    m_irq = 0; m_rst = 0;
    ticks(3);
  endtask

  initial begin : watchdog
    while (cyc < WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ticks(3);
    check(ien == 0 && irq == 0 && rst_req == 0 && miso == 0, "R11 reset state",
          {ien, irq, rst_req, miso}, 0);
    rst_n = 1;
    ticks(3);

    // R4 R5: write with reserved bits set, bit 12 set (ignored)
    frame(16'b01_1_1_1111_1111_0000, 16, 0);
    check(ien == 12'h3F0, "R5 reserved masked", ien, 12'h3F0);
    check(rd == 16'h0000, "R4 old contents on miso", rd, 0);

    // R3 R9: pure read returns contents, no change
    frame(16'b01_0_0_0000_0000_0101, 16, 0);
    check(rd == 16'h03F0, "R9 miso word", rd, 16'h03F0);
    check(ien == 12'h3F0, "R3 read-only keeps ien", ien, 12'h3F0);

    // R4 read-while-write returns previous contents
    frame(16'b01_1_0_0000_1010_0101, 16, 0);
    check(rd == 16'h03F0, "R4 previous on miso", rd, 16'h03F0);
    check(ien == 12'h0A5, "R4 new value", ien, 12'h0A5);

    // R2 other addresses ignored
    frame(16'b10_1_0_0000_0000_1111, 16, 0);
    check(ien == 12'h0A5, "R2 addr 10 ignored", ien, 12'h0A5);
    frame(16'b00_1_0_0000_0000_1111, 16, 0);
    check(ien == 12'h0A5, "R2 addr 00 ignored", ien, 12'h0A5);
    frame(16'b11_1_0_0000_0000_1111, 16, 0);
    check(ien == 12'h0A5, "R2 addr 11 ignored", ien, 12'h0A5);

    // R6: fail-enable (bit 3) clear -> silent drop
    frame(16'b01_1_0_0000_0000_0000, 16, 0);
    frame(16'b01_1_0_0000_0000_1111, 15, 0);
    check(ien == 12'h000, "R6 short frame ignored", ien, 0);
    frame(16'b01_1_0_0000_0000_1111, 17, 1);
    check(ien == 12'h000, "R6 long frame ignored", ien, 0);

    // enable SPI failure bit
    frame(16'b01_1_0_0000_0000_1000, 16, 0);
    check(ien == 12'h008, "R4 set fail enable", ien, 12'h008);

    // R7 short frame -> irq
    frame(16'b01_1_0_0011_0000_0000, 15, 0);
    check(ien == 12'h008, "R7 bad frame keeps ien", ien, 12'h008);
    // R8 strict mode -> reset request
    frame(16'b01_1_0_0011_0000_0000, 17, 1);
    check(ien == 12'h008, "R8 bad frame keeps ien", ien, 12'h008);
    // R10 overrun by many clocks and zero clocks
    frame(16'b01_1_0_0011_0000_0000, 20, 0);
    check(ien == 12'h008, "R10 overrun rejected", ien, 12'h008);
    frame(16'h0000, 0, 1);
    check(ien == 12'h008, "R10 empty frame rejected", ien, 12'h008);
    // R1 exact length still commits afterwards
    frame(16'b01_1_0_0000_0001_1000, 16, 1);
    check(ien == 12'h018, "R1 valid frame commits", ien, 12'h018);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule